// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block holds the protection state of a serial NOR flash and decides, command by command, whether an operation that could alter memory or status may proceed. An SPI front end hands it one event per command when chip select rises: the opcode, the number of bits clocked, the address and the first data byte. The block answers with a one-cycle grant or reject pulse. It keeps the write-enable latch, a four-bit block-protect code, the status-lock bit and the deep-sleep state. A separate query port reports at once whether any address lies in the read-only region.

The controller is a four-state machine. `ST_IDLE` (standby) moves to `ST_EVAL` on `cmd_valid`. `ST_EVAL` returns to `ST_IDLE`, or moves to `ST_SLEEP` when a granted sleep command is judged. `ST_SLEEP` moves to `ST_SLEEP_EVAL` on `cmd_valid`. `ST_SLEEP_EVAL` returns to `ST_IDLE` when a wake command is granted, and otherwise falls back to `ST_SLEEP`. A `cmd_valid` that arrives while a command is being evaluated is ignored, so commands must be spaced at least two cycles apart.

Top module: `spi_wp_ctrl`

## Requirements
- R1: After reset the latch, protect code and lock bit are 0, the block is awake, and neither grant nor reject is asserted.
- R2: A command whose bit count is zero or not a multiple of 8 is rejected and changes no state, both awake and asleep.
- R3: Opcode 0x06 is granted and sets the latch. Program (0x02, 0x38, 0xAD), erase (0x20, 0x52, 0xD8, 0x60, 0xC7), status write (0x01) and lock (0x36, 0x39, 0x7E, 0x98) are rejected while the latch is 0.
- R4: A grant of 0x04 or of any command listed in R3 other than 0x06 clears the latch.
- R5: Each command ends in exactly one grant or reject pulse, one cycle wide. A rejected command leaves the latch, the protect code and the lock bit unchanged.
- R6: A granted 0xB9 puts the block to sleep (dpd=1). While asleep, only 0xAB is granted, and it wakes the block. Every other opcode is rejected without effect.
- R7: Block index = addr[23:16]. Protect code 0 protects nothing and code 15 protects everything. A code n from 1 to 14 protects the top 2^(n-1) blocks, which is all blocks for n of 9 or more. q_prot reports this for q_addr in the same cycle.
- R8: Program and sector/block erase aimed at a protected block are rejected. Chip erase (0x60, 0xC7) is rejected when the protect code is nonzero.
- R9: A granted status write loads the protect code from data[5:2] and the lock bit from data[7]. It is refused when the lock bit is 1, wp_n is 0 and quad_en is 0.
- R10: With quad_en=1 the pin-based refusal of R9 does not apply.
- R11: Read 0x03 is granted without the latch and leaves it unchanged. Lock opcodes need only the latch and no address check. Unknown opcodes are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a command ended at chip-select rise |
| cmd_op | input | 8 | Opcode |
| cmd_bits | input | CNT_W | Bits clocked while chip select was low |
| cmd_addr | input | ADDR_W | Target address |
| cmd_data | input | 8 | First data byte (status value) |
| wp_n | input | 1 | Write-protect pin, active low |
| quad_en | input | 1 | Four-line I/O mode active |
| q_addr | input | ADDR_W | Address to query |
| q_prot | output | 1 | q_addr lies in the protected region |
| grant | output | 1 | Command accepted (pulse) |
| reject | output | 1 | Command refused or discarded (pulse) |
| wel | output | 1 | Write-enable latch |
| bp | output | BP_W | Block-protect code |
| srwd | output | 1 | Status-lock bit |
| dpd | output | 1 | Deep-sleep state |

## Verification
The command is captured at the clock edge where `cmd_valid` is high. The grant or reject pulse, together with any change to the latch, protect code, lock bit or sleep flag, appears after the edge that follows. The bench's monitor therefore records each strobe at the falling edge after capture and compares the result one falling edge later, which is the middle of the pulse cycle. `q_prot` is combinational, so each query is compared a short delay after `q_addr` changes, with no command in flight.

// File: rtl/spiwp_pkg.sv
package spiwp_pkg;

    localparam logic [7:0] OP_WEL_SET    = 8'h06;
    localparam logic [7:0] OP_WEL_CLR    = 8'h04;
    localparam logic [7:0] OP_STAT_WR    = 8'h01;
    localparam logic [7:0] OP_SLEEP      = 8'hB9;
    localparam logic [7:0] OP_WAKE       = 8'hAB;
    localparam logic [7:0] OP_READ       = 8'h03;
    localparam logic [7:0] OP_PROG       = 8'h02;
    localparam logic [7:0] OP_PROG4      = 8'h38;
    localparam logic [7:0] OP_PROG_CONT  = 8'hAD;
    localparam logic [7:0] OP_ERASE_SEC  = 8'h20;
    localparam logic [7:0] OP_ERASE_HALF = 8'h52;
    localparam logic [7:0] OP_ERASE_BLK  = 8'hD8;
    localparam logic [7:0] OP_ERASE_ALLA = 8'h60;
    localparam logic [7:0] OP_ERASE_ALLB = 8'hC7;
    localparam logic [7:0] OP_LOCK_ONE   = 8'h36;
    localparam logic [7:0] OP_UNLOCK_ONE = 8'h39;
    localparam logic [7:0] OP_LOCK_ALL   = 8'h7E;
    localparam logic [7:0] OP_UNLOCK_ALL = 8'h98;

    typedef struct packed {
        logic known;
        logic need_wel;
        logic clr_wel;
        logic set_wel;
        logic addr_chk;
        logic chip_all;
        logic stat_wr;
        logic sleep_in;
        logic wake;
    } cmd_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SLEEP,
        ST_SLEEP_EVAL
    } wp_state_t;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import spiwp_pkg::*;
(
    input  logic [7:0] op,
    output cmd_cls_t   cls
);
    always_comb begin
        cls = '0;
        unique case (op)
            OP_WEL_SET: begin
                cls.known   = 1'b1;
                cls.set_wel = 1'b1;
            end
            OP_WEL_CLR: begin
                cls.known   = 1'b1;
                cls.clr_wel = 1'b1;
            end
            OP_STAT_WR: begin
                cls.known    = 1'b1;
                cls.need_wel = 1'b1;
                cls.clr_wel  = 1'b1;
                cls.stat_wr  = 1'b1;
            end
            OP_PROG, OP_PROG4, OP_PROG_CONT,
            OP_ERASE_SEC, OP_ERASE_HALF, OP_ERASE_BLK: begin
                cls.known    = 1'b1;
                cls.need_wel = 1'b1;
                cls.clr_wel  = 1'b1;
                cls.addr_chk = 1'b1;
            end
            OP_ERASE_ALLA, OP_ERASE_ALLB: begin
                cls.known    = 1'b1;
                cls.need_wel = 1'b1;
                cls.clr_wel  = 1'b1;
                cls.chip_all = 1'b1;
            end
            OP_LOCK_ONE, OP_UNLOCK_ONE, OP_LOCK_ALL, OP_UNLOCK_ALL: begin
                cls.known    = 1'b1;
                cls.need_wel = 1'b1;
                cls.clr_wel  = 1'b1;
            end
            OP_READ: begin
                cls.known = 1'b1;
            end
            OP_SLEEP: begin
                cls.known    = 1'b1;
                cls.sleep_in = 1'b1;
            end
            OP_WAKE: begin
                cls.known = 1'b1;
                cls.wake  = 1'b1;
            end
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/wp_region.sv
module wp_region #(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 8,
    parameter int BP_W   = 4
) (
    input  logic [BP_W-1:0]   code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int NBLK = 1 << BLK_W;
    localparam logic [BP_W-1:0] CODE_ALL = '1;

    logic [BLK_W-1:0] blk;
    int               span;

    assign blk = addr[ADDR_W-1 -: BLK_W];

    // code n (1 .. all-ones minus one) guards the top 2^(n-1) blocks
    always_comb begin
        span = 0;
        hit  = 1'b0;
        if (code == '0) begin
            hit = 1'b0;
        end else if (code == CODE_ALL) begin
            hit = 1'b1;
        end else if ((int'(code) - 1) >= BLK_W) begin
            hit = 1'b1;
        end else begin
            span = 1 << (int'(code) - 1);
            hit  = int'(blk) >= (NBLK - span);
        end
    end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
    import spiwp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 8,
    parameter int BP_W   = 4,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              quad_en,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_prot,
    output logic              grant,
    output logic              reject,
    output logic              wel,
    output logic [BP_W-1:0]   bp,
    output logic              srwd,
    output logic              dpd
);
    localparam int N_PORTS  = 2;
    localparam int SR_LOCK  = 7;
    localparam int BP_LSB   = 2;

    wp_state_t         state_q, state_d;
    logic [7:0]        cap_op;
    logic [CNT_W-1:0]  cap_bits;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;
    logic              wel_q, srwd_q, grant_q, reject_q;
    logic [BP_W-1:0]   bp_q;
    cmd_cls_t          cls;
    logic              len_ok, pin_lock, evaluating, accept, take;
    logic [ADDR_W-1:0] probe_addr [N_PORTS];
    logic [N_PORTS-1:0] probe_hit;

    wp_cmd_decode u_dec (
        .op  (cap_op),
        .cls (cls)
    );

    assign probe_addr[0] = cap_addr;
    assign probe_addr[1] = q_addr;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_region
        wp_region #(
            .ADDR_W (ADDR_W),
            .BLK_W  (BLK_W),
            .BP_W   (BP_W)
        ) u_region (
            .code (bp_q),
            .addr (probe_addr[g]),
            .hit  (probe_hit[g])
        );
    end

    assign len_ok     = (cap_bits != '0) && (cap_bits[2:0] == 3'b000);
    assign pin_lock   = srwd_q && !wp_n && !quad_en;
    assign evaluating = (state_q == ST_EVAL) || (state_q == ST_SLEEP_EVAL);
    assign take       = cmd_valid && ((state_q == ST_IDLE) || (state_q == ST_SLEEP));

    always_comb begin
        accept = 1'b0;
        if (state_q == ST_EVAL) begin
            accept = len_ok && cls.known
                  && !(cls.need_wel && !wel_q)
                  && !(cls.addr_chk && probe_hit[0])
                  && !(cls.chip_all && (bp_q != '0))
                  && !(cls.stat_wr && pin_lock);
        end else if (state_q == ST_SLEEP_EVAL) begin
            accept = len_ok && cls.wake;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (cmd_valid) state_d = ST_EVAL;
            ST_EVAL:       state_d = (accept && cls.sleep_in) ? ST_SLEEP : ST_IDLE;
            ST_SLEEP:      if (cmd_valid) state_d = ST_SLEEP_EVAL;
            ST_SLEEP_EVAL: state_d = accept ? ST_IDLE : ST_SLEEP;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs, capture and protection registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op   <= '0;
            cap_bits <= '0;
            cap_addr <= '0;
            cap_data <= '0;
            wel_q    <= 1'b0;
            srwd_q   <= 1'b0;
            bp_q     <= '0;
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            grant_q  <= evaluating && accept;
            reject_q <= evaluating && !accept;
            if (take) begin
                cap_op   <= cmd_op;
                cap_bits <= cmd_bits;
                cap_addr <= cmd_addr;
                cap_data <= cmd_data;
            end
            if (evaluating && accept) begin
                if (cls.set_wel) wel_q <= 1'b1;
                if (cls.clr_wel) wel_q <= 1'b0;
                if (cls.stat_wr) begin
                    bp_q   <= cap_data[BP_LSB +: BP_W];
                    srwd_q <= cap_data[SR_LOCK];
                end
            end
        end
    end

    assign grant  = grant_q;
    assign reject = reject_q;
    assign wel    = wel_q;
    assign bp     = bp_q;
    assign srwd   = srwd_q;
    assign dpd    = (state_q == ST_SLEEP) || (state_q == ST_SLEEP_EVAL);
    assign q_prot = probe_hit[1];

    a_r2_len_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (evaluating && !len_ok) |=> (reject && $stable(wel) && $stable(bp) && $stable(srwd)));

    a_r3_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && cls.need_wel && !wel) |=> !grant);

    a_r4_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> grant);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || reject) |=> !(grant || reject));

    a_r6_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP_EVAL && !cls.wake) |=> (!grant && dpd));

    a_r8_prot_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && cls.addr_chk && probe_hit[0]) |=> (reject && $stable(wel)));

    a_r9_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && cls.stat_wr && pin_lock) |=> (reject && $stable(bp) && $stable(srwd)));

endmodule

// File: tb/spi_wp_ctrl_tb.sv
module spi_wp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic       g, r, wl, sw, dp;
        logic [3:0] b;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [11:0] cmd_bits = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic        quad_en = 1'b0;
    logic [23:0] q_addr = '0;
    logic        q_prot, grant, reject, wel, srwd, dpd;
    logic [3:0]  bp;

    int   total = 0;
    int   bad = 0;
    bit   seen_prev = 0;
    bit   done = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_wp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .wp_n(wp_n), .quad_en(quad_en), .q_addr(q_addr), .q_prot(q_prot),
        .grant(grant), .reject(reject), .wel(wel), .bp(bp), .srwd(srwd), .dpd(dpd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input int bits, input logic [23:0] a,
                        input logic [7:0] d, input logic eg, input logic ewl,
                        input logic [3:0] eb, input logic esw, input logic edp,
                        input string tag);
        exp_t e;
        e.g = eg; e.r = !eg; e.wl = ewl; e.b = eb; e.sw = esw; e.dp = edp; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); #1;
        cmd_op = op; cmd_bits = 12'(bits); cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic query(input logic [23:0] a, input logic exp, input string tag);
        q_addr = a;
        #1;
        chk(tag, {7'd0, q_prot}, {7'd0, exp});
    endtask

    // monitor: result is due one falling edge after the capture edge is seen
    always @(negedge clk) begin
        if (seen_prev && rst_n) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 actual=unexpected result expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " grant"},  {7'd0, grant},  {7'd0, e.g});
                chk({e.tag, " reject"}, {7'd0, reject}, {7'd0, e.r});
                chk({e.tag, " wel"},    {7'd0, wel},    {7'd0, e.wl});
                chk({e.tag, " bp"},     {4'd0, bp},     {4'd0, e.b});
                chk({e.tag, " srwd"},   {7'd0, srwd},   {7'd0, e.sw});
                chk({e.tag, " dpd"},    {7'd0, dpd},    {7'd0, e.dp});
            end
        end
        seen_prev = cmd_valid;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wel", {7'd0, wel}, 8'd0);
        chk("R1 bp", {4'd0, bp}, 8'd0);
        chk("R1 srwd", {7'd0, srwd}, 8'd0);
        chk("R1 dpd", {7'd0, dpd}, 8'd0);
        chk("R1 pulses", {6'd0, grant, reject}, 8'd0);
        // R3 latch gating
        send(8'h02, 40, 24'h0, 8'h0, 0, 0, 4'd0, 0, 0, "R3 prog without latch");
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd0, 0, 0, "R3 set latch");
        // R2 partial byte
        send(8'h04, 12, 24'h0, 8'h0, 0, 1, 4'd0, 0, 0, "R2 partial-byte clear");
        send(8'h04, 0, 24'h0, 8'h0, 0, 1, 4'd0, 0, 0, "R2 zero length");
        // R4 program clears latch
        send(8'h02, 40, 24'h000000, 8'h0, 1, 0, 4'd0, 0, 0, "R4 program");
        // R9 status write: code 3
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd0, 0, 0, "R3 set latch");
        send(8'h01, 16, 24'h0, 8'h0C, 1, 0, 4'd3, 0, 0, "R9 status load");
        // R7 region code 3 = top 4 blocks
        query(24'hFC0000, 1, "R7 code3 lowest guarded");
        query(24'hFBFFFF, 0, "R7 code3 just below");
        query(24'hFFFFFF, 1, "R7 code3 top");
        query(24'h000000, 0, "R7 code3 bottom");
        // R8 erase into protected block, R5 latch kept
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd3, 0, 0, "R3 set latch");
        send(8'h20, 32, 24'hFD0000, 8'h0, 0, 1, 4'd3, 0, 0, "R8 R5 erase guarded");
        send(8'h20, 32, 24'h100000, 8'h0, 1, 0, 4'd3, 0, 0, "R4 erase open");
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd3, 0, 0, "R3 set latch");
        send(8'hC7, 8, 24'h0, 8'h0, 0, 1, 4'd3, 0, 0, "R8 chip erase guarded");
        send(8'h04, 8, 24'h0, 8'h0, 1, 0, 4'd3, 0, 0, "R4 clear latch");
        // R9 pin lock, R10 quad mode
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd3, 0, 0, "R3 set latch");
        send(8'h01, 16, 24'h0, 8'hBC, 1, 0, 4'd15, 1, 0, "R9 lock bit set");
        query(24'h000000, 1, "R7 code15 all");
        wp_n = 1'b0;
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd15, 1, 0, "R3 set latch");
        send(8'h01, 16, 24'h0, 8'h00, 0, 1, 4'd15, 1, 0, "R9 pin refuses");
        quad_en = 1'b1;
        send(8'h01, 16, 24'h0, 8'h04, 1, 0, 4'd1, 0, 0, "R10 quad overrides pin");
        quad_en = 1'b0;
        wp_n = 1'b1;
        query(24'hFF0000, 1, "R7 code1 top block");
        query(24'hFE0000, 0, "R7 code1 next block");
        // R11 lock, read, unknown
        send(8'h7E, 8, 24'h0, 8'h0, 0, 0, 4'd1, 0, 0, "R11 R3 gang lock no latch");
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd1, 0, 0, "R3 set latch");
        send(8'h36, 32, 24'hFF0000, 8'h0, 1, 0, 4'd1, 0, 0, "R11 R4 lock no addr check");
        send(8'h03, 32, 24'h0, 8'h0, 1, 0, 4'd1, 0, 0, "R11 read");
        send(8'h55, 8, 24'h0, 8'h0, 0, 0, 4'd1, 0, 0, "R11 unknown");
        // R6 sleep
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd1, 0, 0, "R3 set latch");
        send(8'hB9, 8, 24'h0, 8'h0, 1, 1, 4'd1, 0, 1, "R6 enter sleep");
        send(8'h04, 8, 24'h0, 8'h0, 0, 1, 4'd1, 0, 1, "R6 clear ignored asleep");
        send(8'h01, 16, 24'h0, 8'h3C, 0, 1, 4'd1, 0, 1, "R6 status ignored asleep");
        send(8'hAB, 12, 24'h0, 8'h0, 0, 1, 4'd1, 0, 1, "R2 R6 partial wake");
        send(8'hAB, 32, 24'h0, 8'h0, 1, 1, 4'd1, 0, 0, "R6 wake");
        // code 9 guards everything
        send(8'h01, 16, 24'h0, 8'h24, 1, 0, 4'd9, 0, 0, "R9 code9 load");
        query(24'h000000, 1, "R7 code9 all");
        send(8'h06, 8, 24'h0, 8'h0, 1, 1, 4'd9, 0, 0, "R3 set latch");
        send(8'h38, 40, 24'h000000, 8'h0, 0, 1, 4'd9, 0, 0, "R8 quad prog guarded");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R5 actual=%0d pending expected=0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule